// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A requester hands over the virtual address, the base of the first-level table, its privilege level and whether it intends to write. The walker fetches one first-level word. If that word points to a second-level table, it fetches one second-level word. It then reports the physical address, the page kind, the domain, the permission and cache attribute bits, and a fault flag with a code.

Memory is reached through a read port that carries one request at a time. An address is offered with a valid/ready pair, and the data word comes back later with its own valid strobe. The block admits a new walk only while it is idle. A walk may end early on an empty or reserved descriptor. A walk that decodes a mapping is still refused when the two-bit permission field does not allow the requester's privilege and direction.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while idle, including right after reset. A walk starts on a clock edge where `req_valid` and `req_ready` are both high. Requests offered while busy are ignored and do not alter the walk in progress. At most one memory read is outstanding. `mem_req_addr` holds steady while `mem_req_valid` waits for `mem_req_ready`.
- R2: The first read targets the word address {table base bits [31:14], VA bits [31:20], 2'b00}.
- R3: A first-level word whose type bits [1:0] are 00 ends the walk with fault code 1, and a type of 11 ends it with fault code 2. In both cases the walk makes exactly one read, and paddr, kind, domain, ap and cb are all zero.
- R4: Type 10 with bit 18 clear is a 1 MB section, reported as kind 1. Its paddr is {desc[31:20], VA[19:0]}, ap is desc[11:10], cb is desc[3:2] and the domain is desc[8:5].
- R5: Type 10 with bit 18 set is a 16 MB supersection, reported as kind 2. Its paddr is {desc[31:24], VA[23:0]}. Its attributes come from the same fields as a section.
- R6: Type 01 makes a second read, at {desc[31:10], VA[19:12], 2'b00}. The domain reported for the page is that first-level word's bits [8:5].
- R7: A second-level word with type 00 gives fault code 3. The first-level domain is kept, and paddr, kind, ap and cb are zero.
- R8: A second-level type of 01 is a 64 KB page, reported as kind 3. Its paddr is {desc[31:16], VA[15:0]} and cb is desc[3:2]. The ap pair is taken at desc bits [2k+5:2k+4], with k = VA[15:14].
- R9: A second-level type of 10 is a 4 KB page, reported as kind 4. Its paddr is {desc[31:12], VA[11:0]}. Its ap pair is selected in the same way, with k = VA[11:10].
- R10: A second-level type of 11 is a 1 KB page, reported as kind 5. Its paddr is {desc[31:10], VA[9:0]}, ap is desc[5:4] and cb is desc[3:2].
- R11: The permission values are as follows. 00 denies every access. 01 allows privileged reads and writes and denies all user access. 10 allows any privileged access and user reads. 11 allows everything. A denied mapping gives fault code 4 with paddr 0 and kind 0, while domain, ap and cb are still reported.
- R12: `rsp_valid` is high for exactly one cycle, and `req_ready` is high in the following cycle. Suppose memory accepts every request at once and answers in the cycle after acceptance. Then `rsp_valid` is seen 3 cycles after the accepting edge for a one-read walk and 5 cycles after it for a two-read walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle; request accepted this edge if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | First-level table base (bits [31:14] used) |
| req_priv | input | 1 | Requester is privileged |
| req_write | input | 1 | Access intends to write |
| mem_req_valid | output | 1 | Memory read address offered |
| mem_req_ready | input | 1 | Memory accepts the address |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 2 | Selected permission field |
| rsp_cb | output | 2 | Cache/buffer bits |
| rsp_kind | output | 3 | 0 none, 1 section, 2 supersection, 3 64 KB, 4 4 KB, 5 1 KB |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fcode | output | 3 | 0 none, 1 L1 empty, 2 L1 reserved, 3 L2 empty, 4 permission |

## Verification
The result of a walk is due 3 cycles after the accepting edge when one read is made, and 5 cycles after it when two are made, provided memory accepts at once and replies one cycle after acceptance. The bench counts falling edges from the accepting edge to the result strobe and compares that count with the expected latency. It then samples every result field on that same falling edge and checks, one falling edge later, that the strobe has dropped and `req_ready` is high again. In the runs where the memory stalls its ready line, the latency comparison is skipped, but the fields are still checked at the strobe. The memory model also checks each offered address at the falling edge before the accepting edge, and checks that the address stays steady while it is stalled.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned VA_W      = 32;
  localparam int unsigned DESC_W    = 32;
  localparam int unsigned L1_IDX_W  = 12;
  localparam int unsigned L2_IDX_W  = 8;
  localparam int unsigned WORD_B    = 2;
  localparam int unsigned DOM_W     = 4;
  localparam int unsigned AP_W      = 2;
  localparam int unsigned CB_W      = 2;
  localparam int unsigned TYPE_W    = 2;

  localparam int unsigned L1_IDX_LO = VA_W - L1_IDX_W;
  localparam int unsigned L2_IDX_LO = L1_IDX_LO - L2_IDX_W;
  localparam int unsigned L1_TBL_SH = L1_IDX_W + WORD_B;
  localparam int unsigned L2_TBL_SH = L2_IDX_W + WORD_B;

  localparam int unsigned SECT_SH   = L1_IDX_LO;
  localparam int unsigned SUPER_SH  = 24;
  localparam int unsigned LARGE_SH  = 16;
  localparam int unsigned SMALL_SH  = L2_IDX_LO;
  localparam int unsigned TINY_SH   = 10;

  localparam int unsigned SUPER_BIT = 18;
  localparam int unsigned DOM_LO    = 5;
  localparam int unsigned CB_LO     = 2;
  localparam int unsigned AP1_LO    = 10;
  localparam int unsigned AP2_LO    = 4;

  localparam logic [VA_W-1:0] L2_IDX_MASK = VA_W'((1 << L2_IDX_W) - 1);

  localparam logic [TYPE_W-1:0] T1_EMPTY  = 2'b00;
  localparam logic [TYPE_W-1:0] T1_TABLE  = 2'b01;
  localparam logic [TYPE_W-1:0] T1_SECT   = 2'b10;
  localparam logic [TYPE_W-1:0] T2_EMPTY  = 2'b00;
  localparam logic [TYPE_W-1:0] T2_LARGE  = 2'b01;
  localparam logic [TYPE_W-1:0] T2_SMALL  = 2'b10;

  localparam logic [AP_W-1:0] AP_NONE    = 2'b00;
  localparam logic [AP_W-1:0] AP_PRIV    = 2'b01;
  localparam logic [AP_W-1:0] AP_USER_RO = 2'b10;

  typedef enum logic [2:0] {
    K_NONE, K_SECT, K_SUPER, K_LARGE, K_SMALL, K_TINY
  } kind_e;

  typedef enum logic [2:0] {
    F_NONE, F_L1_EMPTY, F_L1_RSVD, F_L2_EMPTY, F_PERM
  } fault_e;

  typedef struct packed {
    logic [VA_W-1:0]  paddr;
    logic [DOM_W-1:0] dom;
    logic [AP_W-1:0]  ap;
    logic [CB_W-1:0]  cb;
    kind_e            kind;
    fault_e           fc;
  } walk_res_t;

  // Mask that keeps bits [VA_W-1:sh].
  function automatic logic [VA_W-1:0] hi_mask(input int unsigned sh);
    logic [VA_W-1:0] m;
    m = {VA_W{1'b1}} << sh;
    return m;
  endfunction

  // Upper bits from the descriptor, lower sh bits from the virtual address.
  function automatic logic [VA_W-1:0] splice(input logic [DESC_W-1:0] d,
                                             input logic [VA_W-1:0] va,
                                             input int unsigned sh);
    return (d & hi_mask(sh)) | (va & ~hi_mask(sh));
  endfunction

  function automatic logic [VA_W-1:0] l1_word_addr(input logic [VA_W-1:0] tbase,
                                                   input logic [VA_W-1:0] va);
    return (tbase & hi_mask(L1_TBL_SH)) | ((va >> L1_IDX_LO) << WORD_B);
  endfunction

  function automatic logic [VA_W-1:0] l2_word_addr(input logic [DESC_W-1:0] d,
                                                   input logic [VA_W-1:0] va);
    return (d & hi_mask(L2_TBL_SH)) | (((va >> L2_IDX_LO) & L2_IDX_MASK) << WORD_B);
  endfunction

  // Permission pair number q taken from the second-level word.
  function automatic logic [AP_W-1:0] ap_pair(input logic [DESC_W-1:0] d,
                                              input logic [1:0] q);
    int unsigned idx;
    idx = AP2_LO + AP_W * int'(q);
    return d[idx +: AP_W];
  endfunction

  function automatic logic perm_allows(input logic [AP_W-1:0] ap,
                                       input logic priv,
                                       input logic wr);
    logic ok;
    unique case (ap)
      AP_NONE:    ok = 1'b0;
      AP_PRIV:    ok = priv;
      AP_USER_RO: ok = priv | ~wr;
      default:    ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
  import xlat_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [VA_W-1:0]   va,
  output walk_res_t         res,
  output logic              descend
);

  always_comb begin
    res     = '0;
    descend = 1'b0;
    unique case (desc[TYPE_W-1:0])
      T1_EMPTY: res.fc = F_L1_EMPTY;
      T1_TABLE: begin
        descend = 1'b1;
        res.dom = desc[DOM_LO +: DOM_W];
      end
      T1_SECT: begin
        res.dom = desc[DOM_LO +: DOM_W];
        res.ap  = desc[AP1_LO +: AP_W];
        res.cb  = desc[CB_LO +: CB_W];
        if (desc[SUPER_BIT]) begin
          res.kind  = K_SUPER;
          res.paddr = splice(desc, va, SUPER_SH);
        end else begin
          res.kind  = K_SECT;
          res.paddr = splice(desc, va, SECT_SH);
        end
      end
      default: res.fc = F_L1_RSVD;
    endcase
  end

endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
  import xlat_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [VA_W-1:0]   va,
  input  logic [DOM_W-1:0]  dom_in,
  output walk_res_t         res
);

  logic [1:0] large_q;
  logic [1:0] small_q;

  assign large_q = va[LARGE_SH-1 -: 2];
  assign small_q = va[SMALL_SH-1 -: 2];

  always_comb begin
    res     = '0;
    res.dom = dom_in;
    unique case (desc[TYPE_W-1:0])
      T2_EMPTY: res.fc = F_L2_EMPTY;
      T2_LARGE: begin
        res.kind  = K_LARGE;
        res.paddr = splice(desc, va, LARGE_SH);
        res.ap    = ap_pair(desc, large_q);
        res.cb    = desc[CB_LO +: CB_W];
      end
      T2_SMALL: begin
        res.kind  = K_SMALL;
        res.paddr = splice(desc, va, SMALL_SH);
        res.ap    = ap_pair(desc, small_q);
        res.cb    = desc[CB_LO +: CB_W];
      end
      default: begin
        res.kind  = K_TINY;
        res.paddr = splice(desc, va, TINY_SH);
        res.ap    = ap_pair(desc, 2'd0);
        res.cb    = desc[CB_LO +: CB_W];
      end
    endcase
  end

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_pkg::*;
(
  input  logic [AP_W-1:0] ap,
  input  logic            priv,
  input  logic            wr,
  output logic            ok
);

  assign ok = perm_allows(ap, priv, wr);

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [VA_W-1:0]   req_tbase,
  input  logic              req_priv,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [DOM_W-1:0]  rsp_domain,
  output logic [AP_W-1:0]   rsp_ap,
  output logic [CB_W-1:0]   rsp_cb,
  output logic [2:0]        rsp_kind,
  output logic              rsp_fault,
  output logic [2:0]        rsp_fcode
);

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } state_e;

  state_e            state;
  logic [VA_W-1:0]   va_q;
  logic [VA_W-1:0]   tbase_q;
  logic              priv_q;
  logic              wr_q;
  logic [DESC_W-1:0] l1d_q;
  walk_res_t         res_q;

  // Named internal events.
  logic walk_start;
  logic l1_done;
  logic l2_done;
  logic walk_end;

  walk_res_t l1_res;
  walk_res_t l2_res;
  walk_res_t dec_sel;
  walk_res_t final_res;
  logic      l1_descend;
  logic      perm_ok;

  assign walk_start = req_valid && req_ready;
  assign l1_done    = (state == S_L1_WAIT) && mem_rsp_valid;
  assign l2_done    = (state == S_L2_WAIT) && mem_rsp_valid;
  assign walk_end   = (l1_done && !l1_descend) || l2_done;

  xlat_l1_decode u_l1 (
    .desc    (mem_rsp_data),
    .va      (va_q),
    .res     (l1_res),
    .descend (l1_descend)
  );

  xlat_l2_decode u_l2 (
    .desc   (mem_rsp_data),
    .va     (va_q),
    .dom_in (l1d_q[DOM_LO +: DOM_W]),
    .res    (l2_res)
  );

  assign dec_sel = (state == S_L2_WAIT) ? l2_res : l1_res;

  xlat_perm_check u_perm (
    .ap   (dec_sel.ap),
    .priv (priv_q),
    .wr   (wr_q),
    .ok   (perm_ok)
  );

  always_comb begin
    final_res = dec_sel;
    if (dec_sel.fc == F_NONE && !perm_ok) begin
      final_res.fc    = F_PERM;
      final_res.paddr = '0;
      final_res.kind  = K_NONE;
    end
  end

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign mem_req_addr  = (state == S_L2_REQ) ? l2_word_addr(l1d_q, va_q)
                                             : l1_word_addr(tbase_q, va_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      tbase_q <= '0;
      priv_q  <= 1'b0;
      wr_q    <= 1'b0;
      l1d_q   <= '0;
      res_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (walk_start) begin
          va_q    <= req_vaddr;
          tbase_q <= req_tbase;
          priv_q  <= req_priv;
          wr_q    <= req_write;
          state   <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state <= S_L1_WAIT;
        S_L1_WAIT: if (l1_done) begin
          if (l1_descend) begin
            l1d_q <= mem_rsp_data;
            state <= S_L2_REQ;
          end else begin
            res_q <= final_res;
            state <= S_RESP;
          end
        end
        S_L2_REQ: if (mem_req_ready) state <= S_L2_WAIT;
        S_L2_WAIT: if (l2_done) begin
          res_q <= final_res;
          state <= S_RESP;
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (state == S_RESP);
  assign rsp_paddr  = res_q.paddr;
  assign rsp_domain = res_q.dom;
  assign rsp_ap     = res_q.ap;
  assign rsp_cb     = res_q.cb;
  assign rsp_kind   = res_q.kind;
  assign rsp_fcode  = res_q.fc;
  assign rsp_fault  = (res_q.fc != F_NONE);

  // Only one read in flight: an accepted address is not re-offered next cycle.
  p_single_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // A stalled address stays offered and unchanged.
  p_hold_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // Once a walk starts, no further request is taken.
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);

  // A walk that stops at level one answers next without a second read.
  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_done && !l1_descend) |=> (rsp_valid && !mem_req_valid));

  // A faulting result carries no address and no kind.
  p_fault_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_kind == 3'd0));

  // A granted result never has the deny-all permission.
  p_granted_ap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_ap != AP_NONE));

  // Result strobe is a single pulse followed by idle.
  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // Every completed decode leads to a strobe on the next cycle.
  p_end_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> rsp_valid);

endmodule

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [31:0] req_tbase;
  logic        req_priv;
  logic        req_write;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_ap;
  logic [1:0]  rsp_cb;
  logic [2:0]  rsp_kind;
  logic        rsp_fault;
  logic [2:0]  rsp_fcode;

  always #2 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_tbase(req_tbase), .req_priv(req_priv), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_domain(rsp_domain), .rsp_ap(rsp_ap), .rsp_cb(rsp_cb),
    .rsp_kind(rsp_kind), .rsp_fault(rsp_fault), .rsp_fcode(rsp_fcode)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] pa;
    logic [3:0]  dom;
    logic [1:0]  ap;
    logic [1:0]  cb;
    logic [2:0]  kind;
    logic [2:0]  fc;
  } exp_t;

  function automatic bit allowed(input logic [1:0] ap, input bit pv, input bit wr);
    if (ap == 2'd3) return 1'b1;
    if (ap == 2'd1) return pv;
    if (ap == 2'd2) return pv || !wr;
    return 1'b0;
  endfunction

  function automatic exp_t model(input logic [31:0] va, input logic [31:0] l1,
                                 input logic [31:0] l2, input bit pv, input bit wr);
    exp_t e;
    int   q;
    e = '0;
    case (l1 & 32'd3)
      32'd0: e.fc = 3'd1;
      32'd3: e.fc = 3'd2;
      32'd2: begin
        e.dom = 4'(l1 >> 5);
        e.ap  = 2'(l1 >> 10);
        e.cb  = 2'(l1 >> 2);
        if (((l1 >> 18) & 32'd1) != 0) begin
          e.kind = 3'd2;
          e.pa   = (l1 & 32'hFF00_0000) | (va & 32'h00FF_FFFF);
        end else begin
          e.kind = 3'd1;
          e.pa   = (l1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
        end
      end
      default: begin
        e.dom = 4'(l1 >> 5);
        case (l2 & 32'd3)
          32'd0: e.fc = 3'd3;
          32'd1: begin
            q      = int'((va >> 14) & 32'd3);
            e.kind = 3'd3;
            e.ap   = 2'(l2 >> (4 + 2 * q));
            e.cb   = 2'(l2 >> 2);
            e.pa   = (l2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF);
          end
          32'd2: begin
            q      = int'((va >> 10) & 32'd3);
            e.kind = 3'd4;
            e.ap   = 2'(l2 >> (4 + 2 * q));
            e.cb   = 2'(l2 >> 2);
            e.pa   = (l2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
          end
          default: begin
            e.kind = 3'd5;
            e.ap   = 2'(l2 >> 4);
            e.cb   = 2'(l2 >> 2);
            e.pa   = (l2 & 32'hFFFF_FC00) | (va & 32'h0000_03FF);
          end
        endcase
      end
    endcase
    if (e.fc == 3'd0 && !allowed(e.ap, pv, wr)) begin
      e.fc   = 3'd4;
      e.pa   = '0;
      e.kind = 3'd0;
    end
    return e;
  endfunction

  // Memory model: decides at each falling edge, answers one cycle after acceptance.
  logic [31:0] cur_l1, cur_l2, exp_l1a, exp_l2a, held_addr, pend_data;
  int          reads = 0;
  bit          stall = 1'b0;
  bit          hs_pend = 1'b0;
  bit          held = 1'b0;
  int unsigned cyc = 0;

  initial begin
    mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
  end

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (hs_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pend_data;
      hs_pend       = 1'b0;
    end
    if (held && mem_req_valid)
      check(mem_req_addr == held_addr, "R1 stalled address", mem_req_addr, held_addr);
    mem_req_ready = stall ? cyc[0] : 1'b1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (reads == 0) begin
        check(mem_req_addr == exp_l1a, "R2 first read address", mem_req_addr, exp_l1a);
        pend_data = cur_l1;
      end else begin
        check(mem_req_addr == exp_l2a, "R6 second read address", mem_req_addr, exp_l2a);
        pend_data = cur_l2;
      end
      reads++;
      hs_pend = 1'b1;
    end
    held      = mem_req_valid && !mem_req_ready;
    held_addr = mem_req_addr;
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] tb,
                          input logic [31:0] l1, input logic [31:0] l2,
                          input bit pv, input bit wr, input string tag);
    exp_t  e;
    bit    two;
    int    lat;
    bit    busy_ok;
    string t;
    e   = model(va, l1, l2, pv, wr);
    two = ((l1 & 32'd3) == 32'd1);
    t   = (e.fc == 3'd4) ? "R11" : tag;
    exp_l1a = (tb & 32'hFFFF_C000) | ((va >> 20) << 2);
    exp_l2a = (l1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2);
    cur_l1  = l1;
    cur_l2  = l2;
    reads   = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 idle ready", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_tbase = tb; req_priv = pv; req_write = wr;
    @(negedge clk);
    // Keep pressing a different request while busy: R1 says it is ignored.
    req_vaddr = ~va; req_tbase = ~tb; req_priv = !pv; req_write = !wr;
    lat = 1;
    busy_ok = 1'b1;
    while (!rsp_valid && lat < 80) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    check(busy_ok, "R1 ready low while busy", {31'b0, busy_ok}, 32'd1);
    if (!rsp_valid) begin
      check(1'b0, "R12 no result strobe", 32'd0, 32'd1);
    end else begin
      if (!stall)
        check(lat == (two ? 5 : 3), "R12 latency", lat, two ? 32'd5 : 32'd3);
      check(rsp_paddr == e.pa, {t, " paddr"}, rsp_paddr, e.pa);
      check({rsp_kind, rsp_fcode} == {e.kind, e.fc}, {t, " kind/fcode"},
            {26'b0, rsp_kind, rsp_fcode}, {26'b0, e.kind, e.fc});
      check(rsp_fault == (e.fc != 3'd0), {t, " fault flag"},
            {31'b0, rsp_fault}, {31'b0, e.fc != 3'd0});
      check({rsp_domain, rsp_ap, rsp_cb} == {e.dom, e.ap, e.cb}, {t, " dom/ap/cb"},
            {24'b0, rsp_domain, rsp_ap, rsp_cb}, {24'b0, e.dom, e.ap, e.cb});
    end
    check(reads == (two ? 2 : 1), two ? "R6 read count" : "R3 read count",
          reads, two ? 32'd2 : 32'd1);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R12 strobe drops, ready returns",
          {30'b0, rsp_valid, req_ready}, 32'd1);
  endtask

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] step(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_tbase = '0;
    req_priv = 1'b0; req_write = 1'b0;
    exp_l1a = '0; exp_l2a = '0; cur_l1 = '0; cur_l2 = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", {31'b0, req_ready}, 32'd1);
    check(!rsp_valid && !mem_req_valid, "R12 reset strobes",
          {30'b0, rsp_valid, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int ap = 0; ap < 4; ap++) begin
        for (int pv = 0; pv < 2; pv++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int q = 0; q < 4; q++) begin
              logic [31:0] va, tb, r3, r4, l1, l2, apf;
              string tag;
              rs = step(rs); va = rs;
              rs = step(rs); tb = rs;
              rs = step(rs); r3 = rs;
              rs = step(rs); r4 = rs;
              va = (va & ~32'h0000_CC00) | (32'(q) << 14) | (32'(3 - q) << 10);
              apf = '0;
              for (int n = 0; n < 4; n++) apf |= 32'((ap + n) % 4) << (4 + 2 * n);
              stall = (q == 2);
              l2 = r4;
              tag = "R3";
              case (k)
                0: l1 = r3 & ~32'd3;
                1: l1 = r3 | 32'd3;
                2: begin l1 = (r3 & ~32'h0004_0C03) | (32'(ap) << 10) | 32'd2; tag = "R4"; end
                3: begin l1 = (r3 & ~32'h0000_0C03) | 32'h0004_0000 | (32'(ap) << 10) | 32'd2; tag = "R5"; end
                default: begin
                  l1 = (r3 & ~32'd3) | 32'd1;
                  l2 = (r4 & ~32'h0000_0FF3) | apf | 32'(k - 4);
                  case (k)
                    4: tag = "R7";
                    5: tag = "R8";
                    6: tag = "R9";
                    default: tag = "R10";
                  endcase
                end
              endcase
              run_walk(va, tb, l1, l2, pv[0], wr[0], tag);
            end
          end
        end
      end
    end
    stall = 1'b0;
    done  = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule